// File: doc/BRIEF.md
# Per-Byte Parity Guard

This block sits between a data bus and a storage array whose words hold nine bits per byte. On the write side it takes a plain data word and adds one parity bit to each byte. The result is the stored word handed to the array. On the read side it splits the stored word back into data and parity. It recomputes each byte's parity and raises a registered error flag for any byte whose stored bit disagrees.

A sense input selects odd or even parity for both generation and checking. A lane-off input hides the ninth bit of every byte from the external read bus, which turns the 18-bit external view into a 16-bit one. The internal parity bit is still produced, stored and checked regardless of lane-off. The byte count is a parameter with a default of two.

Stored word layout: byte k occupies bits [9k+7:9k], and its parity bit sits at bit 9k+8.

Top module: `byte_parity_guard`

## Requirements
- R1: For each byte k, `wr_word_o[9k+7:9k]` equals `wr_data_i[8k+7:8k]` in the same cycle. Bit `9k+8` is the parity bit, chosen so the nine bits hold an odd number of ones when `odd_sense_i`=1 and an even number when `odd_sense_i`=0.
- R2: `rd_data_o[8k+7:8k]` equals `rd_word_i[9k+7:9k]` combinationally.
- R3: With `lane_off_i`=0, `rd_par_o[k]` equals `rd_word_i[9k+8]` combinationally. Tying `lane_off_i` low is the default and leaves the parity lanes active.
- R4: With `lane_off_i`=1, `rd_par_o` is all zeros.
- R5: On the clock edge where `rd_valid_i`=1, `err_o[k]` is loaded with 1 when the nine bits of byte k in `rd_word_i` break the parity selected by `odd_sense_i` in that cycle, and with 0 otherwise. The flag is seen one clock after the read data.
- R6: On a clock edge where `rd_valid_i`=0, every `err_o` bit is loaded with 0.
- R7: `lane_off_i` has no effect on `wr_word_o` or on `err_o`.
- R8: `err_any_o` is 1 exactly when at least one `err_o` bit is 1.
- R9: While `rst_ni` is low, `err_o` and `err_any_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| odd_sense_i | input | 1 | 1 selects odd parity, 0 selects even |
| lane_off_i | input | 1 | 1 hides the external parity lanes |
| wr_data_i | input | NB*8 | Write data from the bus |
| wr_word_o | output | NB*9 | Stored word with parity, to the array |
| rd_valid_i | input | 1 | The read word is valid this cycle |
| rd_word_i | input | NB*9 | Stored word from the array |
| rd_data_o | output | NB*8 | Read data to the bus |
| rd_par_o | output | NB | External parity lanes |
| err_o | output | NB | Registered per-byte parity error |
| err_any_o | output | 1 | OR of all error flags |

## Verification
Parity generation for a write and checking of a read can happen in the same cycle, because the two paths share only the sense input. The bench presents a new write word and a corrupted read word together, under both senses and with the lanes off. It then confirms that the stored word follows the write data at once and that, one clock later, the error flags name exactly the corrupted bytes. It also flips the sense in the same cycle as a read, which checks that the flag is judged against the sense applied at the read edge.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CELL_W = BYTE_W + 1;

  // parity bit that makes the nine-bit group odd (odd_s=1) or even (odd_s=0)
  function automatic logic gen_par(input logic [BYTE_W-1:0] b, input logic odd_s);
    return (^b) ^ odd_s;
  endfunction
endpackage

// File: rtl/parity_encoder.sv
module parity_encoder
  import parity_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  logic                 odd_sense_i,
  input  logic [NB*BYTE_W-1:0] data_i,
  output logic [NB*CELL_W-1:0] word_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_d;
    assign byte_d                  = data_i[k*BYTE_W +: BYTE_W];
    assign word_o[k*CELL_W +: BYTE_W] = byte_d;
    assign word_o[k*CELL_W + BYTE_W]  = gen_par(byte_d, odd_sense_i);
  end
endmodule

// File: rtl/parity_checker.sv
module parity_checker
  import parity_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 odd_sense_i,
  input  logic                 valid_i,
  input  logic [NB*CELL_W-1:0] word_i,
  output logic [NB-1:0]        err_o
);
  logic [NB-1:0] mism;

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BYTE_W-1:0] byte_d;
    logic              par_st;
    assign byte_d  = word_i[k*CELL_W +: BYTE_W];
    assign par_st  = word_i[k*CELL_W + BYTE_W];
    assign mism[k] = par_st ^ gen_par(byte_d, odd_sense_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= '0;
    else if (valid_i) err_o <= mism;
    else              err_o <= '0;
  end
endmodule

// File: rtl/read_splitter.sv
module read_splitter
  import parity_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input  logic                 lane_off_i,
  input  logic [NB*CELL_W-1:0] word_i,
  output logic [NB*BYTE_W-1:0] data_o,
  output logic [NB-1:0]        par_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign data_o[k*BYTE_W +: BYTE_W] = word_i[k*CELL_W +: BYTE_W];
    assign par_o[k] = lane_off_i ? 1'b0 : word_i[k*CELL_W + BYTE_W];
  end
endmodule

// File: rtl/byte_parity_guard.sv
module byte_parity_guard
  import parity_pkg::*;
#(
  parameter int unsigned NB = 2,
  localparam int unsigned DW = NB * BYTE_W,
  localparam int unsigned SW = NB * CELL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          odd_sense_i,
  input  logic          lane_off_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [SW-1:0] wr_word_o,
  input  logic          rd_valid_i,
  input  logic [SW-1:0] rd_word_i,
  output logic [DW-1:0] rd_data_o,
  output logic [NB-1:0] rd_par_o,
  output logic [NB-1:0] err_o,
  output logic          err_any_o
);
  parity_encoder #(.NB(NB)) u_enc (
    .odd_sense_i (odd_sense_i),
    .data_i      (wr_data_i),
    .word_o      (wr_word_o)
  );

  read_splitter #(.NB(NB)) u_split (
    .lane_off_i (lane_off_i),
    .word_i     (rd_word_i),
    .data_o     (rd_data_o),
    .par_o      (rd_par_o)
  );

  parity_checker #(.NB(NB)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .odd_sense_i (odd_sense_i),
    .valid_i     (rd_valid_i),
    .word_i      (rd_word_i),
    .err_o       (err_o)
  );

  assign err_any_o = |err_o;
endmodule

// File: rtl/byte_parity_guard_chk.sv
module byte_parity_guard_chk
  import parity_pkg::*;
#(
  parameter int unsigned NB = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 odd_sense_i,
  input logic                 lane_off_i,
  input logic [NB*BYTE_W-1:0] wr_data_i,
  input logic [NB*CELL_W-1:0] wr_word_o,
  input logic                 rd_valid_i,
  input logic [NB*CELL_W-1:0] rd_word_i,
  input logic [NB-1:0]        rd_par_o,
  input logic [NB-1:0]        err_o,
  input logic                 err_any_o
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    assert_wr_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_word_o[k*CELL_W +: BYTE_W] == wr_data_i[k*BYTE_W +: BYTE_W]);
    assert_wr_parity_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (^wr_word_o[k*CELL_W +: CELL_W]) == odd_sense_i);
    assert_clean_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && ((^rd_word_i[k*CELL_W +: CELL_W]) == odd_sense_i)) |=> !err_o[k]);
    assert_bad_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_valid_i && ((^rd_word_i[k*CELL_W +: CELL_W]) != odd_sense_i)) |=> err_o[k]);
  end

  assert_lane_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_off_i |-> (rd_par_o == '0));
  assert_idle_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> (err_o == '0));
  assert_err_any_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_any_o == (err_o != '0));
  always_comb begin
    if (!rst_ni) assert_reset_R9: assert (err_o == '0 && !err_any_o);
  end
endmodule

bind byte_parity_guard byte_parity_guard_chk #(.NB(NB)) u_guard_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .odd_sense_i (odd_sense_i),
  .lane_off_i  (lane_off_i),
  .wr_data_i   (wr_data_i),
  .wr_word_o   (wr_word_o),
  .rd_valid_i  (rd_valid_i),
  .rd_word_i   (rd_word_i),
  .rd_par_o    (rd_par_o),
  .err_o       (err_o),
  .err_any_o   (err_any_o)
);

// File: tb/byte_parity_guard_test.sv
`timescale 1ns/1ps
module byte_parity_guard_test;
  localparam int NB = 2;
  localparam int DW = NB * 8;
  localparam int SW = NB * 9;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          odd_sense_i = 1'b0;
  logic          lane_off_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [SW-1:0] wr_word_o;
  logic          rd_valid_i = 1'b0;
  logic [SW-1:0] rd_word_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [NB-1:0] rd_par_o;
  logic [NB-1:0] err_o;
  logic          err_any_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  byte_parity_guard #(.NB(NB)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_par(input logic [7:0] b, input logic odd_s);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return odd_s ? ((n % 2) == 0) : ((n % 2) == 1);
  endfunction

  // build a stored word; flip_mask bit k corrupts byte k's parity
  function automatic logic [SW-1:0] mk_word(input logic [DW-1:0] d, input logic odd_s,
                                            input logic [NB-1:0] flip_mask);
    logic [SW-1:0] w;
    for (int k = 0; k < NB; k++) begin
      w[k*9 +: 8] = d[k*8 +: 8];
      w[k*9 + 8]  = ref_par(d[k*8 +: 8], odd_s) ^ flip_mask[k];
    end
    return w;
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk("R9 err", err_o, 0);
    chk("R9 any", err_any_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_write(input logic [DW-1:0] d, input logic odd_s, input logic loff);
    @(negedge clk_i);
    wr_data_i = d; odd_sense_i = odd_s; lane_off_i = loff;
    #1;
    chk(loff ? "R7 wr" : "R1 wr", wr_word_o, mk_word(d, odd_s, '0));
  endtask

  task automatic t_read(input logic [DW-1:0] d, input logic odd_s, input logic loff,
                        input logic [NB-1:0] flips);
    logic [SW-1:0] w;
    w = mk_word(d, odd_s, flips);
    @(negedge clk_i);
    rd_word_i = w; rd_valid_i = 1'b1; odd_sense_i = odd_s; lane_off_i = loff;
    #1;
    chk("R2 data", rd_data_o, d);
    if (loff) chk("R4 lanes", rd_par_o, 0);
    else      chk("R3 lanes", rd_par_o, {w[17], w[8]});
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    chk(loff ? "R7 err" : "R5 err", err_o, flips);
    chk("R8 any", err_any_o, |flips);
  endtask

  task automatic t_idle_clear();
    t_read(16'hA55A, 1'b1, 1'b0, 2'b11);
    @(negedge clk_i);
    chk("R6 err", err_o, 0);
    chk("R6 any", err_any_o, 0);
  endtask

  // write and read in the same cycle
  task automatic t_concurrent(input logic odd_s, input logic loff);
    logic [SW-1:0] w;
    w = mk_word(16'h3CF0, odd_s, 2'b10);
    @(negedge clk_i);
    wr_data_i = 16'h7E81; rd_word_i = w; rd_valid_i = 1'b1;
    odd_sense_i = odd_s; lane_off_i = loff;
    #1;
    chk("R1 conc wr", wr_word_o, mk_word(16'h7E81, odd_s, '0));
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    chk("R5 conc err", err_o, 2'b10);
    chk("R8 conc any", err_any_o, 1'b1);
  endtask

  // sense flips in the read cycle: judged against the new sense
  task automatic t_sense_flip();
    @(negedge clk_i);
    odd_sense_i = 1'b0;
    rd_word_i = mk_word(16'h0103, 1'b1, '0);
    rd_valid_i = 1'b1;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    chk("R5 sense", err_o, 2'b11);
  endtask

  initial begin
    t_reset();
    t_write(16'h0000, 1'b0, 1'b0);
    t_write(16'h0000, 1'b1, 1'b0);
    t_write(16'hFF01, 1'b0, 1'b0);
    t_write(16'h8137, 1'b1, 1'b0);
    t_write(16'h8137, 1'b1, 1'b1);
    t_write(16'hC3E7, 1'b0, 1'b1);
    t_read(16'h1234, 1'b1, 1'b0, 2'b00);
    t_read(16'h1234, 1'b0, 1'b0, 2'b01);
    t_read(16'hFFFF, 1'b1, 1'b0, 2'b10);
    t_read(16'h00FF, 1'b0, 1'b0, 2'b11);
    t_read(16'h5AA5, 1'b1, 1'b1, 2'b01);
    t_read(16'h5AA5, 1'b0, 1'b1, 2'b00);
    t_idle_clear();
    t_concurrent(1'b1, 1'b0);
    t_concurrent(1'b0, 1'b1);
    t_sense_flip();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule